// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the device side of a byte-wide parallel NOR flash, written as a synthesizable clocked model. A host drives active-low chip-enable, write-enable and output-enable strobes together with an address and a data byte. The strobes are sampled on the block clock. A write cycle is a period with chip-enable and write-enable both low. The address is taken when that period opens and the data byte when it closes. A write cycle during which output-enable is ever low is thrown away.

Writes are parsed as multi-cycle unlock command sequences, which start byte program, sector erase, chip erase, boot lockout enable and entry or exit of an identification mode on a small internal array. The array holds 2^MEM_AW bytes split into 2^SECT_W equal sectors. Sector 0 is the boot region. Program and erase times are counts of clock cycles set by parameters. While an operation runs, every read returns a status byte in place of array data. Command decode compares only address bits 11:0. Array and sector decode use address bits MEM_AW-1:0, so higher address bits alias.

The sequencer states are ST_IDLE, ST_UNL1, ST_UNL2, ST_ERA3, ST_ERA4, ST_ERA5, ST_PGM_ARM, ST_PGM_BUSY, ST_ERA_BUSY and ST_FAIL. The transitions are as follows:

- ST_IDLE goes to ST_UNL1 on AA written at 555.
- ST_UNL1 goes to ST_UNL2 on 55 written at AAA or 2AA.
- From ST_UNL2, a write at 555 of A0 goes to ST_PGM_ARM and of 80 goes to ST_ERA3. A write of 90 or F0 at 555 returns to ST_IDLE after setting or clearing ID mode.
- ST_ERA3 goes to ST_ERA4 on AA at 555, and ST_ERA4 goes to ST_ERA5 on 55 at AAA or 2AA.
- From ST_ERA5, 10 at 555 or an allowed 30 goes to ST_ERA_BUSY. 40 at 555 sets the lock and returns to ST_IDLE.
- ST_PGM_ARM goes to ST_PGM_BUSY, or to ST_IDLE when the target is refused.
- ST_PGM_BUSY goes to ST_IDLE on success or to ST_FAIL on timeout. ST_ERA_BUSY goes to ST_IDLE when done.
- ST_FAIL goes to ST_IDLE on F0.
- Any unexpected write in a sequence state returns to ST_IDLE.

Top module: `pflash_ctrl`

## Requirements
- R1: After reset every array byte reads FF, ID mode is off, the boot region is unlocked and the sequencer is in ST_IDLE.
- R2: dout_en is 1 exactly when ce_n=0, oe_n=0 and we_n=1. In read mode dout is the array byte at addr[MEM_AW-1:0].
- R3: Byte program is AA@555, 55@AAA, A0@555, then data@target. PGM_CYC cycles later the byte holds old AND new, so bits only go from 1 to 0.
- R4: While a program is busy, any read returns bit 7 as the complement of the programmed bit 7 and bit 5 as 0. While an erase is busy, bit 7 reads 0. When the operation ends the same read shows array data.
- R5: While busy or failed, each new read strobe inverts bit 6 of the status byte.
- R6: If a program asks for a 0-to-1 change, it runs FAIL_CYC cycles and then enters ST_FAIL. There, reads give bit 5 = 1 and bit 7 = complement of the data bit 7. Only a write of F0 leaves ST_FAIL, and after it the byte holds old AND new.
- R7: Sector erase is AA@555, 55@AAA, 80@555, AA@555, 55@AAA, 30@SA. ERA_CYC cycles later the whole sector of SA (bits MEM_AW-1 down to MEM_AW-SECT_W) reads FF and other sectors are unchanged.
- R8: Chip erase (same five cycles, then 10@555) sets every byte to FF after ERA_CYC cycles, except sector 0 when locked.
- R9: The six-cycle sequence ending 40@555 locks sector 0 until reset. After that, a program or sector erase aimed at sector 0 is refused and the block stays in read mode with the data unchanged.
- R10: The sequence ending 90@555 enters ID mode. In ID mode, reads at 0 give MFG_ID, at 1 give DEV_ID and at 2 give the lock state on bit 0. ID mode is left either by the sequence ending F0@555 or by a single F0 at any address.
- R11: In the second and fifth cycles, address 2AA is accepted as well as AAA. Any wrong data or address in an unlock cycle returns to ST_IDLE without effect.
- R12: Writes made while an erase or program is busy are ignored.
- R13: A write strobe during which oe_n is low is discarded.
- R14: The address is captured when ce_n and we_n are first both low, and the data when either rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Read data valid on dout |

## Verification
The end of a busy program and a read strobe that is still held can fall in the same cycle, and the read data must then switch from status to array contents inside that one read. The bench opens a read during a program, samples it once while busy and again after the count expires without releasing the strobe, and judges the first sample by its polling and timeout bits and the second by the expected AND of old and new data. A second overlap is a full program sequence written while a chip erase runs, judged by the target still reading FF after the erase.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_UNL1, ST_UNL2, ST_ERA3, ST_ERA4, ST_ERA5,
        ST_PGM_ARM, ST_PGM_BUSY, ST_ERA_BUSY, ST_FAIL
    } seq_state_t;

    localparam logic [7:0]  K_UNL_A  = 8'hAA;
    localparam logic [7:0]  K_UNL_B  = 8'h55;
    localparam logic [7:0]  K_PROG   = 8'hA0;
    localparam logic [7:0]  K_ERASE  = 8'h80;
    localparam logic [7:0]  K_ID_IN  = 8'h90;
    localparam logic [7:0]  K_ID_OUT = 8'hF0;
    localparam logic [7:0]  K_CHIP   = 8'h10;
    localparam logic [7:0]  K_SECT   = 8'h30;
    localparam logic [7:0]  K_LOCK   = 8'h40;
    localparam logic [11:0] A_FIRST  = 12'h555;
    localparam logic [11:0] A_SECOND = 12'hAAA;
    localparam logic [11:0] A_SEC_ALT = 12'h2AA;
endpackage

// File: rtl/pf_strobe.sv
module pf_strobe #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_evt
);
    logic wr_act, rd_act, wr_q, rd_q, inh;

    assign wr_act = !ce_n && !we_n;
    assign rd_act = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            inh     <= 1'b0;
            wr_evt  <= 1'b0;
            rd_evt  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_q   <= wr_act;
            rd_q   <= rd_act;
            rd_evt <= rd_act && !rd_q;
            wr_evt <= 1'b0;
            if (wr_act) begin
                inh <= (wr_q ? inh : 1'b0) | !oe_n;
                if (!wr_q) wr_addr <= addr;
            end
            if (!wr_act && wr_q) begin
                wr_data <= din;
                wr_evt  <= !inh;
            end
        end
    end

    AST_WR_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R14
endmodule

// File: rtl/pf_array.sv
module pf_array #(
    parameter int MEM_AW = 8,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] rd_idx,
    input  logic [MEM_AW-1:0] chk_idx,
    input  logic              cm_pgm,
    input  logic              cm_sec,
    input  logic              cm_chip,
    input  logic              keep_boot,
    input  logic [MEM_AW-1:0] op_idx,
    input  logic [7:0]        op_data,
    output logic [7:0]        rd_data,
    output logic [7:0]        chk_data
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int SHIFT = MEM_AW - SECT_W;

    logic [DEPTH-1:0][7:0] cells;
    logic [SECT_W-1:0]     op_sec;

    assign op_sec = op_idx[MEM_AW-1 -: SECT_W];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [SECT_W-1:0] SEC = SECT_W'(i >> SHIFT);
        logic [7:0] word_q;
        logic       wipe;
        assign wipe = (cm_chip && !(keep_boot && SEC == '0)) ||
                      (cm_sec && op_sec == SEC);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                word_q <= 8'hFF;
            else if (wipe)                             word_q <= 8'hFF;
            else if (cm_pgm && op_idx == MEM_AW'(i))   word_q <= word_q & op_data;
        end
        assign cells[i] = word_q;

        AST_PGM_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (cm_pgm && !wipe && op_idx == MEM_AW'(i)) |=>
            ((word_q & ~$past(word_q)) == 8'h00)); // R3
    end

    assign rd_data  = cells[rd_idx];
    assign chk_data = cells[chk_idx];
endmodule

// File: rtl/pf_seq.sv
module pf_seq
    import pflash_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MEM_AW   = 8,
    parameter int SECT_W   = 2,
    parameter int PGM_CYC  = 24,
    parameter int ERA_CYC  = 60,
    parameter int FAIL_CYC = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_evt,
    input  logic [7:0]        chk_data,
    output seq_state_t        state,
    output logic              id_mode,
    output logic              boot_lock,
    output logic              tog,
    output logic              cm_pgm,
    output logic              cm_sec,
    output logic              cm_chip,
    output logic [MEM_AW-1:0] op_idx,
    output logic [7:0]        op_data
);
    localparam int MAXC  = (FAIL_CYC > ERA_CYC) ? FAIL_CYC : ERA_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt, lim;
    logic             era_chip, pgm_ok, busy, cnt_done;
    logic             at_first, at_second, tgt_boot;
    logic [11:0]      a12;

    assign a12       = wr_addr[11:0];
    assign at_first  = (a12 == A_FIRST);
    assign at_second = (a12 == A_SECOND) || (a12 == A_SEC_ALT);
    assign tgt_boot  = (wr_addr[MEM_AW-1 -: SECT_W] == '0);
    assign busy      = (state == ST_PGM_BUSY) || (state == ST_ERA_BUSY);
    assign lim       = (state == ST_ERA_BUSY) ? CNT_W'(ERA_CYC - 1) :
                       pgm_ok ? CNT_W'(PGM_CYC - 1) : CNT_W'(FAIL_CYC - 1);
    assign cnt_done  = busy && (cnt == lim);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (wr_evt && wr_data == K_UNL_A && at_first) nxt = ST_UNL1;
            ST_UNL1:     if (wr_evt) nxt = (wr_data == K_UNL_B && at_second) ? ST_UNL2 : ST_IDLE;
            ST_UNL2:     if (wr_evt) begin
                             if (at_first && wr_data == K_PROG)       nxt = ST_PGM_ARM;
                             else if (at_first && wr_data == K_ERASE) nxt = ST_ERA3;
                             else                                     nxt = ST_IDLE;
                         end
            ST_ERA3:     if (wr_evt) nxt = (wr_data == K_UNL_A && at_first) ? ST_ERA4 : ST_IDLE;
            ST_ERA4:     if (wr_evt) nxt = (wr_data == K_UNL_B && at_second) ? ST_ERA5 : ST_IDLE;
            ST_ERA5:     if (wr_evt) begin
                             if (wr_data == K_CHIP && at_first)                 nxt = ST_ERA_BUSY;
                             else if (wr_data == K_SECT && !(boot_lock && tgt_boot)) nxt = ST_ERA_BUSY;
                             else                                               nxt = ST_IDLE;
                         end
            ST_PGM_ARM:  if (wr_evt) nxt = (boot_lock && tgt_boot) ? ST_IDLE : ST_PGM_BUSY;
            ST_PGM_BUSY: if (cnt_done) nxt = pgm_ok ? ST_IDLE : ST_FAIL;
            ST_ERA_BUSY: if (cnt_done) nxt = ST_IDLE;
            ST_FAIL:     if (wr_evt && wr_data == K_ID_OUT) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // commit outputs
    always_comb begin
        cm_pgm  = (state == ST_PGM_BUSY) && cnt_done;
        cm_sec  = (state == ST_ERA_BUSY) && cnt_done && !era_chip;
        cm_chip = (state == ST_ERA_BUSY) && cnt_done && era_chip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            era_chip  <= 1'b0;
            op_idx    <= '0;
            op_data   <= 8'hFF;
            pgm_ok    <= 1'b1;
            id_mode   <= 1'b0;
            boot_lock <= 1'b0;
            tog       <= 1'b0;
        end else begin
            if (busy && !cnt_done) cnt <= cnt + 1'b1;
            else                   cnt <= '0;
            if (rd_evt && (busy || state == ST_FAIL)) tog <= ~tog;
            if (wr_evt) begin
                if (state == ST_ERA5) begin
                    era_chip <= (wr_data == K_CHIP) && at_first;
                    op_idx   <= wr_addr[MEM_AW-1:0];
                    if (wr_data == K_LOCK && at_first) boot_lock <= 1'b1;
                end
                if (state == ST_PGM_ARM) begin
                    op_idx  <= wr_addr[MEM_AW-1:0];
                    op_data <= wr_data;
                    pgm_ok  <= ((chk_data & wr_data) == wr_data);
                end
                if (state == ST_UNL2 && at_first && wr_data == K_ID_IN) id_mode <= 1'b1;
                if (wr_data == K_ID_OUT &&
                    ((state == ST_UNL2 && at_first) || state == ST_IDLE || state == ST_FAIL))
                    id_mode <= 1'b0;
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_lock |=> boot_lock); // R9
    AST_NO_BOOT_PGM: assert property (@(posedge clk) disable iff (!rst_n)
        cm_pgm |-> !(boot_lock && op_idx[MEM_AW-1 -: SECT_W] == '0)); // R9
    AST_ERA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERA_BUSY && !cnt_done) |=> (state == ST_ERA_BUSY)); // R12
    AST_FAIL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL && !(wr_evt && wr_data == K_ID_OUT)) |=> (state == ST_FAIL)); // R6
endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
    import pflash_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter int         MEM_AW   = 8,
    parameter int         SECT_W   = 2,
    parameter int         PGM_CYC  = 24,
    parameter int         ERA_CYC  = 60,
    parameter int         FAIL_CYC = 80,
    parameter logic [7:0] MFG_ID   = 8'hC5,
    parameter logic [7:0] DEV_ID   = 8'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    logic              wr_evt, rd_evt, id_mode, boot_lock, tog;
    logic              cm_pgm, cm_sec, cm_chip;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, chk_data, rd_data, op_data, id_byte;
    logic [MEM_AW-1:0] op_idx;
    seq_state_t        state;

    pf_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_evt(rd_evt));

    pf_seq #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SECT_W(SECT_W),
             .PGM_CYC(PGM_CYC), .ERA_CYC(ERA_CYC), .FAIL_CYC(FAIL_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_evt(rd_evt), .chk_data(chk_data), .state(state),
        .id_mode(id_mode), .boot_lock(boot_lock), .tog(tog), .cm_pgm(cm_pgm),
        .cm_sec(cm_sec), .cm_chip(cm_chip), .op_idx(op_idx), .op_data(op_data));

    pf_array #(.MEM_AW(MEM_AW), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_idx(addr[MEM_AW-1:0]),
        .chk_idx(wr_addr[MEM_AW-1:0]), .cm_pgm(cm_pgm), .cm_sec(cm_sec),
        .cm_chip(cm_chip), .keep_boot(boot_lock), .op_idx(op_idx),
        .op_data(op_data), .rd_data(rd_data), .chk_data(chk_data));

    // read-side outputs
    always_comb begin
        dout_en = !ce_n && !oe_n && we_n;
        id_byte = 8'h00;
        if (addr[ADDR_W-1:2] == '0) begin
            unique case (addr[1:0])
                2'd0:    id_byte = MFG_ID;
                2'd1:    id_byte = DEV_ID;
                2'd2:    id_byte = {7'b0, boot_lock};
                default: id_byte = 8'h00;
            endcase
        end
        unique case (state)
            ST_PGM_BUSY: dout = {~op_data[7], tog, 1'b0, 5'b0};
            ST_ERA_BUSY: dout = {1'b0, tog, 6'b0};
            ST_FAIL:     dout = {~op_data[7], tog, 1'b1, 5'b0};
            default:     dout = id_mode ? id_byte : rd_data;
        endcase
    end

    AST_STATUS_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERA_BUSY) |-> (dout[7] == 1'b0 && dout[5] == 1'b0)); // R4
endmodule

// File: tb/sim_pflash_ctrl.sv
module sim_pflash_ctrl;
    localparam logic [7:0] MFG = 8'hC5;
    localparam logic [7:0] DEV = 8'h3A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    int          checks = 0, fails = 0, cyc = 0;
    logic [7:0]  v1, v2;

    pflash_ctrl u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
                    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act timeout exp finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic oe_low);
        @(negedge clk); addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unl(input logic [7:0] c);
        wr(12'h555, 8'hAA, 1'b0); wr(12'hAAA, 8'h55, 1'b0); wr(12'h555, c, 1'b0);
    endtask

    task automatic erase6(input logic [11:0] a, input logic [7:0] d);
        unl(8'h80); wr(12'h555, 8'hAA, 1'b0); wr(12'hAAA, 8'h55, 1'b0); wr(a, d, 1'b0);
    endtask

    task automatic prog(input logic [11:0] a, input logic [7:0] d);
        unl(8'hA0); wr(a, d, 1'b0);
    endtask

    // op: 0 write, 1 read-check, 2 wait; fields {op, req, addr, data}
    localparam int NV = 20;
    localparam logic [25:0] TBL [0:NV-1] = '{
        {2'd0, 4'd3,  12'h555, 8'hAA}, {2'd0, 4'd3, 12'hAAA, 8'h55},   // R3
        {2'd0, 4'd3,  12'h555, 8'hA0}, {2'd0, 4'd3, 12'h085, 8'h5A},
        {2'd2, 4'd3,  12'h000, 8'd40}, {2'd1, 4'd3, 12'h085, 8'h5A},
        {2'd0, 4'd11, 12'h555, 8'hAA}, {2'd0, 4'd11, 12'h2AA, 8'h55}, // R11 alias
        {2'd0, 4'd11, 12'h555, 8'hA0}, {2'd0, 4'd11, 12'h085, 8'h12},
        {2'd2, 4'd3,  12'h000, 8'd40}, {2'd1, 4'd3, 12'h085, 8'h12},  // R3 clears only
        {2'd0, 4'd11, 12'h555, 8'hAA}, {2'd0, 4'd11, 12'h555, 8'h55}, // R11 bad cycle
        {2'd0, 4'd11, 12'h555, 8'hA0}, {2'd0, 4'd11, 12'h086, 8'h00},
        {2'd1, 4'd11, 12'h086, 8'hFF},
        {2'd0, 4'd10, 12'h555, 8'hAA}, {2'd0, 4'd10, 12'hAAA, 8'h55}, // R10
        {2'd0, 4'd10, 12'h555, 8'h90}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 output enable
        chk("R2 en idle", {7'b0, dout_en}, 8'h00);
        rd(12'h000, v1); chk("R1 erased 000", v1, 8'hFF);
        rd(12'h0FF, v1); chk("R1 erased 0FF", v1, 8'hFF);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; @(negedge clk);
        chk("R2 en on", {7'b0, dout_en}, 8'h01);
        we_n = 1'b0; @(negedge clk);
        chk("R2 en off we", {7'b0, dout_en}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op; logic [3:0] rq; logic [11:0] a; logic [7:0] d;
            {op, rq, a, d} = TBL[i];
            if (op == 2'd0) wr(a, d, 1'b0);
            else if (op == 2'd2) repeat (int'(d)) @(negedge clk);
            else begin
                rd(a, v1);
                chk($sformatf("R%0d table %0d", rq, i), v1, d);
            end
        end
        rd(12'h000, v1); chk("R10 mfg", v1, MFG);
        rd(12'h001, v1); chk("R10 dev", v1, DEV);
        rd(12'h002, v1); chk("R10 lock bit clear", v1, 8'h00);
        wr(12'h123, 8'hF0, 1'b0);
        rd(12'h085, v1); chk("R10 single exit", v1, 8'h12);

        prog(12'h045, 8'h3C); repeat (40) @(negedge clk);
        rd(12'h045, v1); chk("R3 prog 045", v1, 8'h3C);

        // R14 skewed strobe, R4 polling, R5 toggle
        unl(8'hA0);
        @(negedge clk); addr = 12'h090; din = 8'h00; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = 12'h091; din = 8'h33;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(12'h090, v1);
        chk("R4 pgm bit7", {7'b0, v1[7]}, 8'h01);
        chk("R4 pgm bit5", {7'b0, v1[5]}, 8'h00);
        rd(12'h090, v2);
        chk("R5 toggle", {7'b0, v2[6]}, {7'b0, ~v1[6]});
        @(negedge clk); addr = 12'h090; ce_n = 1'b0; oe_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R4 held read data", dout, 8'h33);
        ce_n = 1'b1; oe_n = 1'b1; @(negedge clk);
        rd(12'h091, v1); chk("R14 addr at start", v1, 8'hFF);

        // R6 timeout
        prog(12'h085, 8'hF0); repeat (100) @(negedge clk);
        rd(12'h085, v1);
        chk("R6 bit5", {7'b0, v1[5]}, 8'h01);
        chk("R6 bit7", {7'b0, v1[7]}, 8'h00);
        wr(12'h555, 8'hAA, 1'b0);
        rd(12'h085, v1); chk("R6 still failed", {7'b0, v1[5]}, 8'h01);
        wr(12'h700, 8'hF0, 1'b0);
        rd(12'h085, v1); chk("R6 after exit", v1, 8'h10);

        // R7 sector erase of sector 2
        erase6(12'h0A0, 8'h30);
        rd(12'h085, v1);
        chk("R4 erase bit7", {7'b0, v1[7]}, 8'h00);
        repeat (80) @(negedge clk);
        rd(12'h085, v1); chk("R7 erased 085", v1, 8'hFF);
        rd(12'h090, v1); chk("R7 erased 090", v1, 8'hFF);
        rd(12'h045, v1); chk("R7 other sector kept", v1, 8'h3C);

        // R9 lockout
        prog(12'h010, 8'h77); repeat (40) @(negedge clk);
        rd(12'h010, v1); chk("R9 boot prog unlocked", v1, 8'h77);
        erase6(12'h555, 8'h40);
        unl(8'h90);
        rd(12'h002, v1); chk("R9 lock bit", v1, 8'h01);
        unl(8'hF0);
        rd(12'h010, v1); chk("R10 seq exit", v1, 8'h77);
        prog(12'h010, 8'h00);
        rd(12'h010, v1); chk("R9 prog refused", v1, 8'h77);
        erase6(12'h020, 8'h30);
        rd(12'h010, v1); chk("R9 sector erase refused", v1, 8'h77);

        // R8 chip erase, R12 writes during erase ignored
        erase6(12'h555, 8'h10);
        prog(12'h050, 8'h00);
        rd(12'h050, v1); chk("R4 chip erase bit7", {7'b0, v1[7]}, 8'h00);
        repeat (100) @(negedge clk);
        rd(12'h045, v1); chk("R8 chip erased", v1, 8'hFF);
        rd(12'h050, v1); chk("R12 prog ignored", v1, 8'hFF);
        rd(12'h010, v1); chk("R8 boot kept locked", v1, 8'h77);

        // R13 OE low inhibits
        wr(12'h555, 8'hAA, 1'b1); wr(12'hAAA, 8'h55, 1'b0);
        wr(12'h555, 8'hA0, 1'b0); wr(12'h060, 8'h00, 1'b0);
        repeat (40) @(negedge clk);
        rd(12'h060, v1); chk("R13 inhibited", v1, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule